// File: doc/BRIEF.md
# JTAG Source Selection Switch

This block sits in front of one on-chip TAP controller and decides which of two masters drives it. One master is the set of dedicated external JTAG pins. The other is a scan-engine port that a processor drives. The block forwards the clock, mode-select, data-in and reset lines of the chosen master to the TAP. It returns the TAP's data-out to that master only. The master that is not chosen sees a constant 0.

A small control register holds two bits. One is the requested source: 0 selects the pins, 1 selects the scan engine. The other is the enable bit for the scan-engine chain. A new source request does not act at once. It waits until all four activity lines are low: the clock and reset lines of both masters. It then takes effect in a single changeover cycle, during which the TAP sees a parked pattern.

Whenever the scan-engine link becomes established, the block holds the TAP in reset for a fixed number of cycles. The TAP then starts from a known state. Two status bits report the source in use and whether a change is still waiting.

Top module: `jtag_src_switch`

## Requirements
- R1: After reset, `sel_active` is 0, `sel_pending` is 0, and the TAP follows the external pins.
- R2: With the pins in use and no changeover in progress, `tap_tck/tms/tdi/trst` equal `pin_tck/tms/tdi/trst`. `pin_tdo` equals `tap_tdo`, and `eng_tdo` is 0.
- R3: With the scan engine in use, its chain enabled, and no reset pulse or changeover in progress, the TAP lines equal the `eng_*` inputs. `eng_tdo` equals `tap_tdo`, and `pin_tdo` is 0.
- R4: With the scan engine selected but `chain_en` clear, the TAP is parked: tck=0, tms=1, tdi=0, trst=0. Both returned data outputs are 0.
- R5: A select write made while any of `pin_tck`, `pin_trst`, `eng_tck`, `eng_trst` is 1 sets `sel_pending` on the next cycle. `sel_active` is unchanged, and the old source stays routed for as long as any of those four lines stays high.
- R6: In the first cycle in which a request is pending and all four activity lines are 0, the TAP is parked (tck=0, tms=1, tdi=0, trst=0). At the next clock edge, `sel_active` takes the requested value and `sel_pending` clears.
- R7: When `sel_active`=1 and `chain_en`=1 become true together, the TAP sees trst=1, tck=0, tms=1, tdi=0 for exactly TRST_CYCLES cycles (default 4), starting at that edge. The engine lines are routed after that. `eng_tdo` carries `tap_tdo` during the pulse.
- R8: Writing a select value equal to the source in use clears `sel_pending` on the next cycle, which cancels a waiting change.
- R9: A write to the control register (`cfg_we`=1) loads the requested source from `cfg_sel` (1 = scan engine) and the chain-enable bit from `cfg_chain_en`. Both load at the next edge, whatever the activity lines are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low cold reset |
| pin_tck | input | 1 | External pin clock |
| pin_tms | input | 1 | External pin mode select |
| pin_tdi | input | 1 | External pin data in |
| pin_trst | input | 1 | External pin TAP reset, 1 = asserted |
| pin_tdo | output | 1 | Data out returned to the pins |
| eng_tck | input | 1 | Scan-engine clock |
| eng_tms | input | 1 | Scan-engine mode select |
| eng_tdi | input | 1 | Scan-engine data in |
| eng_trst | input | 1 | Scan-engine TAP reset, 1 = asserted |
| eng_tdo | output | 1 | Data out returned to the scan engine |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | Requested source, 1 = scan engine |
| cfg_chain_en | input | 1 | Scan-engine chain enable |
| tap_tck | output | 1 | Clock to the TAP |
| tap_tms | output | 1 | Mode select to the TAP |
| tap_tdi | output | 1 | Data in to the TAP |
| tap_trst | output | 1 | Reset to the TAP, 1 = asserted |
| tap_tdo | input | 1 | Data out from the TAP |
| sel_active | output | 1 | Source in use, 1 = scan engine |
| sel_pending | output | 1 | A source change is waiting for idle |

## Verification
Directed sequences first walk through pin routing and engine routing with distinct bit patterns, so that a swapped or stuck line shows up. They then issue a select write while one master is busy. Checks confirm that the old route holds and that a later matching write cancels the request. A further directed case counts the reset-pulse cycles exactly, which separates an off-by-one pulse from a correct one. A long random run then mixes bursts of activity with sparse writes. Each cycle is compared against a reference model, which catches changeovers taken while a master is active and leaks of `tap_tdo` to the inactive side.

// File: rtl/jtsw_pkg.sv
package jtsw_pkg;

    typedef struct packed {
        logic tck;
        logic tms;
        logic tdi;
        logic trst;
    } jtag_sig_t;

    localparam jtag_sig_t PARK_SIG  = '{tck: 1'b0, tms: 1'b1, tdi: 1'b0, trst: 1'b0};
    localparam jtag_sig_t RESET_SIG = '{tck: 1'b0, tms: 1'b1, tdi: 1'b0, trst: 1'b1};

    typedef struct packed {
        logic src;   // source in use, 1 = scan engine
        logic req;   // requested source
        logic chen;  // chain enable
        logic link;  // engine linked to TAP
    } ctrl_state_t;

endpackage

// File: rtl/jtsw_sel_ctrl.sv
module jtsw_sel_ctrl
    import jtsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    input  logic cfg_we_i,
    input  logic cfg_sel_i,
    input  logic cfg_chain_en_i,
    output logic src_o,
    output logic chain_en_o,
    output logic pending_o,
    output logic apply_o,
    output logic link_rise_o
);

    ctrl_state_t state_d, state_q;
    logic        pend;

    always_comb begin
        state_d     = state_q;
        pend        = state_q.req != state_q.src;
        apply_o     = pend && idle_i;
        if (apply_o) begin
            state_d.src = state_q.req;
        end
        if (cfg_we_i) begin
            state_d.req  = cfg_sel_i;
            state_d.chen = cfg_chain_en_i;
        end
        state_d.link = state_d.src && state_d.chen;
        link_rise_o  = state_d.link && !state_q.link;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign src_o      = state_q.src;
    assign chain_en_o = state_q.chen;
    assign pending_o  = pend;

    // R6: the source only changes after an idle cycle
    a_r6_switch_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.src != $past(state_q.src)) |-> $past(idle_i));

    // R5: a busy cycle never moves the source
    a_r5_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |=> $stable(state_q.src));

    // R6: a pending request seen in an idle cycle without a new write is gone next cycle
    a_r6_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && idle_i && !cfg_we_i) |=> !pending_o);

endmodule

// File: rtl/jtsw_trst_pulse.sv
module jtsw_trst_pulse #(
    parameter int TRST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);

    localparam int CW = $clog2(TRST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(TRST_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active_o = cnt_q != '0;

    // R7: a link start always produces a reset pulse on the next cycle
    a_r7_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> active_o);

endmodule

// File: rtl/jtsw_route.sv
module jtsw_route
    import jtsw_pkg::*;
(
    input  logic      src_i,
    input  logic      chain_en_i,
    input  logic      apply_i,
    input  logic      pulse_i,
    input  jtag_sig_t pin_i,
    input  jtag_sig_t eng_i,
    input  logic      tap_tdo_i,
    output jtag_sig_t tap_o,
    output logic      pin_tdo_o,
    output logic      eng_tdo_o
);

    always_comb begin
        tap_o     = PARK_SIG;
        pin_tdo_o = 1'b0;
        eng_tdo_o = 1'b0;
        if (apply_i) begin
            tap_o = PARK_SIG;
        end else if (!src_i) begin
            tap_o     = pin_i;
            pin_tdo_o = tap_tdo_i;
        end else if (!chain_en_i) begin
            tap_o = PARK_SIG;
        end else if (pulse_i) begin
            tap_o     = RESET_SIG;
            eng_tdo_o = tap_tdo_i;
        end else begin
            tap_o     = eng_i;
            eng_tdo_o = tap_tdo_i;
        end
    end

endmodule

// File: rtl/jtag_src_switch.sv
module jtag_src_switch
    import jtsw_pkg::*;
#(
    parameter int TRST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_tck,
    input  logic pin_tms,
    input  logic pin_tdi,
    input  logic pin_trst,
    output logic pin_tdo,
    input  logic eng_tck,
    input  logic eng_tms,
    input  logic eng_tdi,
    input  logic eng_trst,
    output logic eng_tdo,
    input  logic cfg_we,
    input  logic cfg_sel,
    input  logic cfg_chain_en,
    output logic tap_tck,
    output logic tap_tms,
    output logic tap_tdi,
    output logic tap_trst,
    input  logic tap_tdo,
    output logic sel_active,
    output logic sel_pending
);

    jtag_sig_t pin_sig, eng_sig, tap_sig;
    logic      idle, src, chain_en, apply, link_rise, pulse;

    assign pin_sig = '{tck: pin_tck, tms: pin_tms, tdi: pin_tdi, trst: pin_trst};
    assign eng_sig = '{tck: eng_tck, tms: eng_tms, tdi: eng_tdi, trst: eng_trst};
    assign idle    = !(pin_tck || pin_trst || eng_tck || eng_trst);

    jtsw_sel_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .idle_i         (idle),
        .cfg_we_i       (cfg_we),
        .cfg_sel_i      (cfg_sel),
        .cfg_chain_en_i (cfg_chain_en),
        .src_o          (src),
        .chain_en_o     (chain_en),
        .pending_o      (sel_pending),
        .apply_o        (apply),
        .link_rise_o    (link_rise)
    );

    jtsw_trst_pulse #(.TRST_CYCLES(TRST_CYCLES)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (link_rise),
        .active_o (pulse)
    );

    jtsw_route u_route (
        .src_i      (src),
        .chain_en_i (chain_en),
        .apply_i    (apply),
        .pulse_i    (pulse),
        .pin_i      (pin_sig),
        .eng_i      (eng_sig),
        .tap_tdo_i  (tap_tdo),
        .tap_o      (tap_sig),
        .pin_tdo_o  (pin_tdo),
        .eng_tdo_o  (eng_tdo)
    );

    assign tap_tck    = tap_sig.tck;
    assign tap_tms    = tap_sig.tms;
    assign tap_tdi    = tap_sig.tdi;
    assign tap_trst   = tap_sig.trst;
    assign sel_active = src;

    // R4: no TAP clock reaches the TAP while the engine is selected but unlinked
    a_r4_no_clock_unlinked: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_active && !chain_en) |-> !tap_tck);

    // R2: the engine never sees TAP data while the pins are in use
    a_r2_no_tdo_leak: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_active && !sel_pending) |-> !eng_tdo);

endmodule

// File: tb/jtag_src_switch_bench.sv
`timescale 1ns/1ps
module jtag_src_switch_bench;

    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] p = '0, e = '0;
    logic we = 0, sel = 0, cen = 0, tdo = 0;
    logic pin_tdo, eng_tdo, tap_tck, tap_tms, tap_tdi, tap_trst, sel_active, sel_pending;

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state
    logic m_src = 0, m_req = 0, m_chen = 0, m_link = 0;
    int   m_cnt = 0;

    always #2.5 clk = ~clk;

    jtag_src_switch #(.TRST_CYCLES(N)) u_jtag_src_switch (
        .clk(clk), .rst_n(rst_n),
        .pin_tck(p[3]), .pin_tms(p[2]), .pin_tdi(p[1]), .pin_trst(p[0]), .pin_tdo(pin_tdo),
        .eng_tck(e[3]), .eng_tms(e[2]), .eng_tdi(e[1]), .eng_trst(e[0]), .eng_tdo(eng_tdo),
        .cfg_we(we), .cfg_sel(sel), .cfg_chain_en(cen),
        .tap_tck(tap_tck), .tap_tms(tap_tms), .tap_tdi(tap_tdi), .tap_trst(tap_trst),
        .tap_tdo(tdo), .sel_active(sel_active), .sel_pending(sel_pending)
    );

    function automatic logic is_idle(logic [3:0] pp, logic [3:0] ee);
        return !(pp[3] || pp[0] || ee[3] || ee[0]);
    endfunction

    // expected {tck,tms,tdi,trst,pin_tdo,eng_tdo,active,pending}
    function automatic logic [7:0] exp_out(logic [3:0] pp, logic [3:0] ee, logic t);
        logic [3:0] tap;
        logic pt, et, pend;
        pend = m_req != m_src;
        pt = 0; et = 0;
        if (pend && is_idle(pp, ee))    tap = 4'b0100;
        else if (!m_src)               begin tap = pp; pt = t; end
        else if (!m_chen)              tap = 4'b0100;
        else if (m_cnt > 0)            begin tap = 4'b0101; et = t; end
        else                           begin tap = ee; et = t; end
        return {tap, pt, et, m_src, pend};
    endfunction

    function automatic string tag_of(logic [3:0] pp, logic [3:0] ee);
        logic pend;
        pend = m_req != m_src;
        if (pend && is_idle(pp, ee)) return "R6";
        if (pend)                    return "R5";
        if (!m_src)                  return "R2";
        if (!m_chen)                 return "R4";
        if (m_cnt > 0)               return "R7";
        return "R3";
    endfunction

    task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic model_step(logic [3:0] pp, logic [3:0] ee, logic w, logic s, logic c);
        logic nl;
        if (m_req != m_src && is_idle(pp, ee)) m_src = m_req;
        if (w) begin m_req = s; m_chen = c; end   // R9
        nl = m_src && m_chen;
        if (nl && !m_link) m_cnt = N;
        else if (m_cnt > 0) m_cnt--;
        m_link = nl;
    endtask

    task automatic cyc(logic [3:0] pp, logic [3:0] ee, logic w, logic s, logic c, logic t);
        @(negedge clk);
        p = pp; e = ee; we = w; sel = s; cen = c; tdo = t;
        #1;
        chk({tap_tck, tap_tms, tap_tdi, tap_trst, pin_tdo, eng_tdo, sel_active, sel_pending},
            exp_out(pp, ee, t), tag_of(pp, ee));
        @(posedge clk);
        model_step(pp, ee, w, s, c);
    endtask

    initial begin
        void'($urandom(32'd2024));
        p = 4'b0110;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, pins routed
        chk({tap_tck, tap_tms, tap_tdi, tap_trst, sel_active, sel_pending},
            {4'b0110, 2'b00}, "R1");
        @(negedge clk) rst_n = 1'b1;

        // R2: pin routing with distinct patterns
        cyc(4'b1010, 4'b0000, 0, 0, 0, 1);
        cyc(4'b0101, 4'b0110, 0, 0, 0, 0);
        cyc(4'b0111, 4'b1000, 0, 0, 0, 1);

        // R5: write while pins busy stays pending
        cyc(4'b1000, 4'b0000, 1, 1, 1, 1);
        cyc(4'b1110, 4'b0000, 0, 0, 0, 1);
        #1 chk({7'b0, sel_active}, 8'd0, "R5");
        // R8: cancel by writing current source
        cyc(4'b1000, 4'b0000, 1, 0, 1, 0);
        #1 chk({7'b0, sel_pending}, 8'd0, "R8");

        // R6: request again while busy, then idle to apply
        cyc(4'b0001, 4'b0000, 1, 1, 1, 0);
        cyc(4'b0000, 4'b0110, 0, 0, 0, 1);
        #1 chk({6'b0, sel_active, sel_pending}, 8'b10, "R6");
        // R7: count reset pulse cycles
        begin
            int n = 0;
            for (int i = 0; i < 8; i++) begin
                if (i > 0) #1;
                if (tap_trst) n++;
                cyc(4'b0000, 4'b0010, 0, 0, 0, 1);
            end
            chk(8'(n), 8'(N), "R7");
        end

        // R3: engine routing
        cyc(4'b1111, 4'b1010, 0, 0, 0, 1);
        cyc(4'b0000, 4'b0110, 0, 0, 0, 0);
        cyc(4'b1001, 4'b1101, 0, 0, 0, 1);

        // R4: chain disabled while engine selected
        cyc(4'b0000, 4'b1110, 1, 1, 0, 1);
        cyc(4'b0000, 4'b1110, 0, 0, 0, 1);
        cyc(4'b1010, 4'b0110, 0, 0, 0, 1);
        // R7: re-enable chain starts a new pulse
        cyc(4'b0000, 4'b0000, 1, 1, 1, 1);
        cyc(4'b0000, 4'b1000, 0, 0, 0, 1);

        // random mix, all requirements checked by the model
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] rp, re;
            rp = 4'($urandom);
            re = 4'($urandom);
            if ($urandom % 4 != 0) begin rp[3] = 0; rp[0] = 0; end
            if ($urandom % 4 != 0) begin re[3] = 0; re[0] = 0; end
            cyc(rp, re, ($urandom % 8) == 0, 1'($urandom), ($urandom % 4) != 0, 1'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule